// File: doc/BRIEF.md
# SPI-Mode Memory Card Block Data Engine

This engine runs the data phase of one block transfer to a memory card in SPI mode, once the command for that transfer has already been answered. It does not drive the serial lines itself. Each byte goes through a byte-wide SPI master over a request/done handshake, and the engine tells the master, byte by byte, whether to run at the slow or the fast clock divisor. Block bytes move between the card and a buffer through a simple address/strobe port whose byte address starts at zero.

On a read, the engine clocks out idle bytes until the card answers with a byte other than all-ones. That byte must be the start token. The engine then stores the requested number of bytes and clocks in three trailing bytes, which it discards. On a write, the engine sends an idle byte, the start token, the block bytes and three zero bytes. It then polls until the card stops signalling busy. Each transfer ends with a one-cycle completion pulse that carries one of three results: ok, timeout or I/O error.

The control is one state machine with these states:
- IDLE: waits for `start`. Goes to RD_POLL or WR_LEAD depending on `dir_write`.
- RD_POLL: polls for the token. Goes to RD_DATA on the token, to FINISH on an error or timeout, or stays for the next poll.
- RD_DATA: stores block bytes. Goes to RD_TAIL after the last one.
- RD_TAIL: clocks in the trailing bytes. Goes to FINISH after the third.
- WR_LEAD: sends the idle byte, then goes to WR_TOKEN.
- WR_TOKEN: sends the start token, then goes to WR_FETCH.
- WR_FETCH: requests one buffer byte, then goes to WR_DATA.
- WR_DATA: sends that byte. Goes back to WR_FETCH, or to WR_FILL after the last byte.
- WR_FILL: sends the zero bytes, then goes to WR_BUSY.
- WR_BUSY: polls until busy ends, then goes to FINISH on ok, error or timeout.
- FINISH: raises `done` for one cycle, then returns to IDLE.

Top module: `sdspi_blk_engine`

## Requirements
- R1: A `start` pulse is accepted only in IDLE, where it latches `dir_write` and `xfer_len` (1 to 512). A `start` while `busy` is high has no effect. In IDLE the engine raises none of `spi_req`, `buf_wr_en` or `buf_rd_req`.
- R2: On a read, each poll transmits 0xFF. Polling continues while the received byte is 0xFF. A received 0xFE starts the data phase.
- R3: On a read, a first non-0xFF byte other than 0xFE ends the transfer with status 2 (I/O error), and no buffer write takes place.
- R4: On a read, if 1000 polls in a row all return 0xFF, the transfer ends with status 1 (timeout). A 0xFE on the 1000th poll still succeeds.
- R5: After the token, exactly `xfer_len` bytes are received and each is written through `buf_wr_en`/`buf_wr_data` to addresses 0, 1, 2 and so on. Then three more bytes (tx 0xFF) are clocked in and discarded, and the transfer ends with status 0.
- R6: On a write, the transmitted sequence is 0xFF, 0xFE, buffer bytes from addresses 0 to `xfer_len`-1, then 0x00 three times. `buf_rd_data` is sampled in the cycle after `buf_rd_req`.
- R7: After the write filler, the engine polls (tx 0xFF) until a received byte equals 0xFF and then ends with status 0. After 1000 polls without 0xFF it ends with status 1.
- R8: `spi_slow` is low on the requests for block data bytes and high on every other request: tokens, idle bytes, polls, trailing bytes and filler.
- R9: If `spi_overrun` arrives with the byte of a read-token poll or a write-busy poll, the transfer ends with status 2, whatever the byte's value.
- R10: There is one `spi_req` pulse per byte. The next request comes only after `spi_done` has answered the previous one.
- R11: `done` is a one-cycle pulse. `status` is 0 for ok, 1 for timeout and 2 for I/O error, and it is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only in IDLE) |
| dir_write | input | 1 | 1 = write block, 0 = read block |
| xfer_len | input | 10 | Block length in bytes, 1 to 512 |
| busy | output | 1 | High from the cycle after an accepted start through the `done` cycle |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result: 0 ok, 1 timeout, 2 I/O error |
| spi_req | output | 1 | Request one byte exchange from the SPI master |
| spi_tx_byte | output | 8 | Byte to transmit, valid with `spi_req` |
| spi_slow | output | 1 | Divisor select for the requested byte, 1 = slow |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx_byte | input | 8 | Received byte, valid with `spi_done` |
| spi_overrun | input | 1 | Receive overrun flag, valid with `spi_done` |
| buf_addr | output | 9 | Buffer byte address |
| buf_wr_en | output | 1 | Store `buf_wr_data` at `buf_addr` |
| buf_wr_data | output | 8 | Received block byte |
| buf_rd_req | output | 1 | Fetch the byte at `buf_addr` |
| buf_rd_data | input | 8 | Fetched byte, valid the cycle after `buf_rd_req` |

## Verification
Two decisions can fall on the same returned byte. An overrun flag can arrive with a byte that would otherwise be the valid start token. The 1000th poll can deliver the token just as the timeout limit is reached. The bench provokes the first case by raising the overrun flag on the very byte that carries 0xFE, and judges it by an I/O-error status with no buffer writes. It provokes the second by holding the token back to exactly the last allowed poll, and judges it by an ok status with the full block stored, set against a run of all-0xFF polls that must time out.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_POLL,
        ST_RD_DATA,
        ST_RD_TAIL,
        ST_WR_LEAD,
        ST_WR_TOKEN,
        ST_WR_FETCH,
        ST_WR_DATA,
        ST_WR_FILL,
        ST_WR_BUSY,
        ST_FINISH
    } sbe_state_t;

    typedef enum logic [1:0] {
        XS_OK      = 2'd0,
        XS_TIMEOUT = 2'd1,
        XS_IOERR   = 2'd2
    } sbe_status_t;

    localparam logic [7:0] BYTE_IDLE  = 8'hFF;
    localparam logic [7:0] BYTE_START = 8'hFE;
    localparam logic [7:0] BYTE_FILL  = 8'h00;

endpackage

// File: rtl/sbe_byte_port.sv
// Tracks one outstanding byte exchange with the SPI master.
module sbe_byte_port (
    input  logic clk,
    input  logic rst_n,
    input  logic want_byte,
    input  logic spi_done,
    output logic spi_req,
    output logic byte_done
);
    logic waiting_q;

    assign spi_req   = want_byte && !waiting_q;
    assign byte_done = waiting_q && spi_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
        end else if (spi_req) begin
            waiting_q <= 1'b1;
        end else if (byte_done) begin
            waiting_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sbe_step_ctr.sv
// Clearable up-counter used for poll/tail counting and buffer addressing.
module sbe_step_ctr #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + WIDTH'(1);
        end
    end
endmodule

// File: rtl/sdspi_blk_engine.sv
module sdspi_blk_engine
    import sbe_pkg::*;
#(
    parameter int MAX_LEN    = 512,
    parameter int POLL_LIMIT = 1000,
    parameter int TAIL_BYTES = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           dir_write,
    input  logic [$clog2(MAX_LEN+1)-1:0]   xfer_len,
    output logic                           busy,
    output logic                           done,
    output logic [1:0]                     status,
    output logic                           spi_req,
    output logic [7:0]                     spi_tx_byte,
    output logic                           spi_slow,
    input  logic                           spi_done,
    input  logic [7:0]                     spi_rx_byte,
    input  logic                           spi_overrun,
    output logic [$clog2(MAX_LEN)-1:0]     buf_addr,
    output logic                           buf_wr_en,
    output logic [7:0]                     buf_wr_data,
    output logic                           buf_rd_req,
    input  logic [7:0]                     buf_rd_data
);
    localparam int LEN_W  = $clog2(MAX_LEN + 1);
    localparam int ADDR_W = $clog2(MAX_LEN);
    localparam int CNT_W  = $clog2(POLL_LIMIT + 1);
    localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(POLL_LIMIT - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_BYTES - 1);

    sbe_state_t        state_q, state_d;
    sbe_status_t       status_q, status_d;
    logic              status_set;
    logic [LEN_W-1:0]  len_q;
    logic              accept;

    logic              want_byte;
    logic              byte_done;
    logic              cnt_clr, cnt_inc;
    logic [CNT_W-1:0]  cnt;
    logic              addr_clr, addr_inc;
    logic [ADDR_W-1:0] addr;
    logic              last_data;

    // ---------------- sub-blocks ----------------
    sbe_byte_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .want_byte (want_byte),
        .spi_done  (spi_done),
        .spi_req   (spi_req),
        .byte_done (byte_done)
    );

    sbe_step_ctr #(.WIDTH(CNT_W)) u_poll_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    sbe_step_ctr #(.WIDTH(ADDR_W)) u_addr_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .inc   (addr_inc),
        .count (addr)
    );

    assign accept    = (state_q == ST_IDLE) && start;
    assign last_data = ({1'b0, addr} == (LEN_W + 1)'(len_q - LEN_W'(1)));

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            status_q <= XS_OK;
            len_q    <= '0;
        end else begin
            state_q <= state_d;
            if (status_set) begin
                status_q <= status_d;
            end
            if (accept) begin
                len_q <= xfer_len;
            end
        end
    end

    // ---------------- next state and counter control ----------------
    always_comb begin
        state_d    = state_q;
        status_d   = XS_OK;
        status_set = 1'b0;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        addr_clr   = 1'b0;
        addr_inc   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cnt_clr  = 1'b1;
                    addr_clr = 1'b1;
                    state_d  = dir_write ? ST_WR_LEAD : ST_RD_POLL;
                end
            end
            ST_RD_POLL: begin
                if (byte_done) begin
                    if (spi_overrun) begin
                        status_d   = XS_IOERR;
                        status_set = 1'b1;
                        state_d    = ST_FINISH;
                    end else if (spi_rx_byte != BYTE_IDLE) begin
                        if (spi_rx_byte == BYTE_START) begin
                            state_d = ST_RD_DATA;
                        end else begin
                            status_d   = XS_IOERR;
                            status_set = 1'b1;
                            state_d    = ST_FINISH;
                        end
                    end else if (cnt == POLL_LAST) begin
                        status_d   = XS_TIMEOUT;
                        status_set = 1'b1;
                        state_d    = ST_FINISH;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_RD_DATA: begin
                if (byte_done) begin
                    addr_inc = 1'b1;
                    if (last_data) begin
                        cnt_clr = 1'b1;
                        state_d = ST_RD_TAIL;
                    end
                end
            end
            ST_RD_TAIL: begin
                if (byte_done) begin
                    if (cnt == TAIL_LAST) begin
                        status_d   = XS_OK;
                        status_set = 1'b1;
                        state_d    = ST_FINISH;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_WR_LEAD: begin
                if (byte_done) begin
                    state_d = ST_WR_TOKEN;
                end
            end
            ST_WR_TOKEN: begin
                if (byte_done) begin
                    state_d = ST_WR_FETCH;
                end
            end
            ST_WR_FETCH: begin
                state_d = ST_WR_DATA;
            end
            ST_WR_DATA: begin
                if (byte_done) begin
                    addr_inc = 1'b1;
                    if (last_data) begin
                        cnt_clr = 1'b1;
                        state_d = ST_WR_FILL;
                    end else begin
                        state_d = ST_WR_FETCH;
                    end
                end
            end
            ST_WR_FILL: begin
                if (byte_done) begin
                    if (cnt == TAIL_LAST) begin
                        cnt_clr = 1'b1;
                        state_d = ST_WR_BUSY;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_WR_BUSY: begin
                if (byte_done) begin
                    if (spi_overrun) begin
                        status_d   = XS_IOERR;
                        status_set = 1'b1;
                        state_d    = ST_FINISH;
                    end else if (spi_rx_byte == BYTE_IDLE) begin
                        status_d   = XS_OK;
                        status_set = 1'b1;
                        state_d    = ST_FINISH;
                    end else if (cnt == POLL_LAST) begin
                        status_d   = XS_TIMEOUT;
                        status_set = 1'b1;
                        state_d    = ST_FINISH;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        want_byte   = 1'b0;
        spi_tx_byte = BYTE_IDLE;
        spi_slow    = 1'b1;
        buf_wr_en   = 1'b0;
        buf_rd_req  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                want_byte = 1'b0;
            end
            ST_RD_POLL, ST_RD_TAIL, ST_WR_LEAD, ST_WR_BUSY: begin
                want_byte = 1'b1;
            end
            ST_RD_DATA: begin
                want_byte = 1'b1;
                spi_slow  = 1'b0;
                buf_wr_en = byte_done;
            end
            ST_WR_TOKEN: begin
                want_byte   = 1'b1;
                spi_tx_byte = BYTE_START;
            end
            ST_WR_FETCH: begin
                buf_rd_req = 1'b1;
            end
            ST_WR_DATA: begin
                want_byte   = 1'b1;
                spi_slow    = 1'b0;
                spi_tx_byte = buf_rd_data;
            end
            ST_WR_FILL: begin
                want_byte   = 1'b1;
                spi_tx_byte = BYTE_FILL;
            end
            default: begin
                want_byte = 1'b0;
            end
        endcase
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_FINISH);
    assign status      = status_q;
    assign buf_addr    = addr;
    assign buf_wr_data = spi_rx_byte;

endmodule

// File: rtl/sbe_checker.sv
module sbe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       spi_req,
    input logic       spi_slow,
    input logic       buf_wr_en,
    input logic       buf_rd_req
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!spi_req && !buf_wr_en && !buf_rd_req)); // R1

    AST_STORE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> !spi_slow); // R8

    AST_FETCH_THEN_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_req |=> (spi_req && !spi_slow)); // R6

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |=> !spi_req); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'd3)); // R11
endmodule

bind sdspi_blk_engine sbe_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .spi_req    (spi_req),
    .spi_slow   (spi_slow),
    .buf_wr_en  (buf_wr_en),
    .buf_rd_req (buf_rd_req)
);

// File: tb/sdspi_blk_engine_tb_top.sv
module sdspi_blk_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LOGN = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dir_write = 1'b0;
    logic [9:0] xfer_len = '0;
    logic       busy, done;
    logic [1:0] status;
    logic       spi_req, spi_slow;
    logic [7:0] spi_tx_byte;
    logic       spi_done = 1'b0;
    logic [7:0] spi_rx_byte = 8'hFF;
    logic       spi_overrun = 1'b0;
    logic [8:0] buf_addr;
    logic       buf_wr_en, buf_rd_req;
    logic [7:0] buf_wr_data;
    logic [7:0] buf_rd_data = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdspi_blk_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
        .xfer_len(xfer_len), .busy(busy), .done(done), .status(status),
        .spi_req(spi_req), .spi_tx_byte(spi_tx_byte), .spi_slow(spi_slow),
        .spi_done(spi_done), .spi_rx_byte(spi_rx_byte), .spi_overrun(spi_overrun),
        .buf_addr(buf_addr), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
        .buf_rd_req(buf_rd_req), .buf_rd_data(buf_rd_data)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // scenario data (set by tasks, read by models)
    logic [7:0] rx_script [0:LOGN-1];
    logic [7:0] src_mem   [0:511];
    int         ovr_idx = -1;
    int         base_req = 0;

    // model results
    logic [7:0] tx_log   [0:LOGN-1];
    bit         slow_log [0:LOGN-1];
    logic [7:0] wmem     [0:511];
    int         req_total = 0;
    int         wr_total = 0;
    int         cur_idx = 0;
    int         cd = 0;

    // SPI master model: answers each request two cycles later
    always @(posedge clk) begin
        spi_done    <= 1'b0;
        spi_overrun <= 1'b0;
        if (spi_req) begin
            tx_log[(req_total - base_req) % LOGN]   <= spi_tx_byte;
            slow_log[(req_total - base_req) % LOGN] <= spi_slow;
            cur_idx   <= req_total - base_req;
            req_total <= req_total + 1;
            cd        <= 2;
        end else if (cd == 1) begin
            spi_done    <= 1'b1;
            spi_rx_byte <= rx_script[cur_idx % LOGN];
            spi_overrun <= (cur_idx == ovr_idx);
            cd          <= 0;
        end else if (cd != 0) begin
            cd <= cd - 1;
        end
    end

    // Buffer model: registered read, write strobe
    always @(posedge clk) begin
        if (buf_wr_en) begin
            wmem[buf_addr] <= buf_wr_data;
            wr_total <= wr_total + 1;
        end
        if (buf_rd_req) begin
            buf_rd_data <= src_mem[buf_addr];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill_script(input logic [7:0] v);
        for (int i = 0; i < LOGN; i++) rx_script[i] = v;
        ovr_idx = -1;
    endtask

    int run_status, run_reqs, run_wrs;

    // Starts a transfer and waits for done; optional stray start after 'stray_at' cycles
    task automatic run_xfer(input bit wr, input int len, input int stray_at);
        int wr_base;
        int cyc;
        @(negedge clk);
        base_req  = req_total;
        wr_base   = wr_total;
        start     = 1'b1;
        dir_write = wr;
        xfer_len  = 10'(len);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        run_status = -1;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (cyc == stray_at) begin
                start = 1'b1; dir_write = ~wr; xfer_len = 10'd7;
                @(negedge clk);
                start = 1'b0;
                cyc++;
            end
        end
        if (done) run_status = int'(status);
        else check(1'b0, "R11 done never seen", 0, 1);
        @(negedge clk);
        run_reqs = req_total - base_req;
        run_wrs  = wr_total - wr_base;
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(done == 1'b0, "R11 reset done", done, 0);
        check(spi_req == 1'b0 && buf_wr_en == 1'b0 && buf_rd_req == 1'b0, "R1 reset quiet", spi_req, 0);
    endtask

    task automatic t_read_ok();
        bit slow_ok = 1;
        bit tx_ok = 1;
        fill_script(8'hFF);
        rx_script[3] = 8'hFE;
        for (int i = 0; i < 4; i++) rx_script[4+i] = 8'(8'h51 + 8'(i * 7));
        rx_script[8] = 8'h12; rx_script[9] = 8'h34; rx_script[10] = 8'h56;
        run_xfer(1'b0, 4, 0);
        check(run_status == 0, "R5 read status ok", run_status, 0);
        check(run_reqs == 11, "R5 read byte count", run_reqs, 11);
        check(run_wrs == 4, "R5 read stores", run_wrs, 4);
        for (int i = 0; i < 4; i++)
            check(wmem[i] == 8'(8'h51 + 8'(i * 7)), "R5 read data", int'(wmem[i]), 8'h51 + i * 7);
        for (int i = 0; i < 11; i++) begin
            if (slow_log[i] != !(i >= 4 && i < 8)) slow_ok = 0;
            if (tx_log[i] != 8'hFF) tx_ok = 0;
        end
        check(slow_ok, "R8 read divisor pattern", slow_ok, 1);
        check(tx_ok, "R2 read tx all 0xFF", tx_ok, 1);
    endtask

    task automatic t_read_badtoken();
        fill_script(8'hFF);
        rx_script[1] = 8'h3C;
        run_xfer(1'b0, 8, 0);
        check(run_status == 2, "R3 bad token status", run_status, 2);
        check(run_wrs == 0, "R3 bad token no stores", run_wrs, 0);
        check(run_reqs == 2, "R3 bad token byte count", run_reqs, 2);
    endtask

    task automatic t_read_timeout();
        fill_script(8'hFF);
        run_xfer(1'b0, 2, 0);
        check(run_status == 1, "R4 read timeout status", run_status, 1);
        check(run_reqs == 1000, "R4 read timeout polls", run_reqs, 1000);
        check(run_wrs == 0, "R4 read timeout stores", run_wrs, 0);
    endtask

    task automatic t_read_late_token();
        fill_script(8'hFF);
        rx_script[999]  = 8'hFE;
        rx_script[1000] = 8'hA7;
        run_xfer(1'b0, 1, 0);
        check(run_status == 0, "R4 token on last poll", run_status, 0);
        check(run_wrs == 1 && wmem[0] == 8'hA7, "R4 last-poll data", int'(wmem[0]), 8'hA7);
        check(run_reqs == 1004, "R4 last-poll byte count", run_reqs, 1004);
    endtask

    task automatic t_read_overrun();
        fill_script(8'hFF);
        rx_script[2] = 8'hFE;
        ovr_idx = 2;
        run_xfer(1'b0, 4, 0);
        check(run_status == 2, "R9 overrun on token", run_status, 2);
        check(run_wrs == 0, "R9 overrun no stores", run_wrs, 0);
    endtask

    task automatic t_write_ok();
        bit seq_ok = 1;
        bit slow_ok = 1;
        logic [7:0] exp_b;
        for (int i = 0; i < 512; i++) src_mem[i] = 8'(i * 3 + 1);
        fill_script(8'h00);
        rx_script[12] = 8'hFF;
        run_xfer(1'b1, 5, 0);
        check(run_status == 0, "R7 write status ok", run_status, 0);
        check(run_reqs == 13, "R7 write byte count", run_reqs, 13);
        for (int i = 0; i < 13; i++) begin
            if (i == 0) exp_b = 8'hFF;
            else if (i == 1) exp_b = 8'hFE;
            else if (i < 7) exp_b = 8'((i - 2) * 3 + 1);
            else if (i < 10) exp_b = 8'h00;
            else exp_b = 8'hFF;
            if (tx_log[i] != exp_b) begin
                seq_ok = 0;
                $display("FAIL R6 tx byte %0d actual=%0d expected=%0d", i, tx_log[i], exp_b);
            end
            if (slow_log[i] != !(i >= 2 && i < 7)) slow_ok = 0;
        end
        check(seq_ok, "R6 write tx sequence", seq_ok, 1);
        check(slow_ok, "R8 write divisor pattern", slow_ok, 1);
        check(run_wrs == 0, "R6 write no stores", run_wrs, 0);
    endtask

    task automatic t_write_timeout();
        fill_script(8'h00);
        run_xfer(1'b1, 2, 0);
        check(run_status == 1, "R7 busy timeout status", run_status, 1);
        check(run_reqs == 7 + 1000, "R7 busy timeout polls", run_reqs, 1007);
    endtask

    task automatic t_write_overrun();
        fill_script(8'h00);
        rx_script[8] = 8'hFF;
        ovr_idx = 8;
        run_xfer(1'b1, 3, 0);
        check(run_status == 2, "R9 overrun on busy poll", run_status, 2);
        check(run_reqs == 9, "R9 busy poll count", run_reqs, 9);
    endtask

    task automatic t_stray_start();
        bit no_token = 1;
        fill_script(8'hFF);
        rx_script[0] = 8'hFE;
        rx_script[1] = 8'h0A; rx_script[2] = 8'h0B;
        run_xfer(1'b0, 2, 3);
        for (int i = 0; i < run_reqs; i++) if (tx_log[i] != 8'hFF) no_token = 0;
        check(run_status == 0, "R1 stray start status", run_status, 0);
        check(run_reqs == 6, "R1 stray start byte count", run_reqs, 6);
        check(run_wrs == 2 && no_token, "R1 stray start kept read", run_wrs, 2);
    endtask

    task automatic t_max_len();
        bit data_ok = 1;
        fill_script(8'hFF);
        rx_script[0] = 8'hFE;
        for (int i = 0; i < 512; i++) rx_script[1+i] = 8'(i ^ 8'h5A);
        run_xfer(1'b0, 512, 0);
        for (int i = 0; i < 512; i++) if (wmem[i] != 8'(i ^ 8'h5A)) data_ok = 0;
        check(run_status == 0, "R5 full block status", run_status, 0);
        check(run_wrs == 512, "R5 full block stores", run_wrs, 512);
        check(data_ok, "R5 full block data", data_ok, 1);
        check(run_reqs == 516, "R10 full block one request per byte", run_reqs, 516);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_ok();
        t_read_badtoken();
        t_read_timeout();
        t_read_late_token();
        t_read_overrun();
        t_write_ok();
        t_write_timeout();
        t_write_overrun();
        t_stray_start();
        t_max_len();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule